// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block arbitrates between a combined reset request and a small set of maskable interrupt sources for a compact microcontroller core. Each interrupt source raises a one-cycle request that is latched into a pending flag. A pending flag is accepted only when two bits are set: the source's own enable bit and a global interrupt-enable bit (the I-bit). On acceptance the block emits a one-cycle take strobe together with the program-memory vector address of the winning source. It then clears both the I-bit and that source's pending flag.

The vector table starts at program address zero. Reset uses 0x000. Source 0 (external interrupt) uses 0x001. Source 1 (timer overflow) uses 0x002. A lower address means a higher priority. Reset cannot be masked and overrides everything. Pin, power-on and watchdog resets are merged into one request before they reach this block.

The status register is neither saved nor restored here; software handles that. A return-from-interrupt strobe sets the I-bit again, so any flags left pending are then served in priority order.

Top module: `irq_vector_ctrl`

## Requirements
- R1: One cycle after a cycle in which `rst` or `sys_rst_req` is high, `vec_addr` is 0x000, `take_irq` is 0, `gie` is 0, all pending flags are 0 and all enable bits are 0.
- R2: Reset wins over interrupts. If `sys_rst_req` is high in the cycle where an interrupt would be accepted, no take strobe follows and `vec_addr` becomes 0x000.
- R3: The vector for source i is i+1. Source 0 (external) gives 0x001 and source 1 (timer) gives 0x002.
- R4: A high `irq_req[i]` sets pending flag `irq_pend[i]`, visible one cycle later. The flag stays set while the source is masked.
- R5: A pending source is accepted only when its enable bit (`en_wdata` bit i, written with `en_wr`) is 1 and `gie` is 1. Otherwise no take strobe occurs.
- R6: When several sources are pending and enabled, the lowest index is accepted first. The next one is accepted after the I-bit is set again.
- R7: An accepted interrupt is seen one cycle after the arbitration cycle: `take_irq` is high for exactly one cycle, `gie` is 0, and the winner's pending flag is 0.
- R8: `reti` sets `gie` to 1 one cycle later. An interrupt still pending and enabled is accepted one cycle after that.
- R9: `gie_wr` loads `gie` with `gie_wdata` one cycle later.
- R10: `vec_addr` holds its last value while no interrupt is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| sys_rst_req | input | 1 | Combined pin, power-on and watchdog reset request |
| irq_req | input | NUM_IRQ | Per-source interrupt request; bit 0 is external, bit 1 is timer |
| en_wr | input | 1 | Write strobe for the enable bits |
| en_wdata | input | NUM_IRQ | New per-source enable bits |
| gie_wr | input | 1 | Write strobe for the global I-bit |
| gie_wdata | input | 1 | New I-bit value |
| reti | input | 1 | Return-from-interrupt strobe; sets the I-bit |
| take_irq | output | 1 | One-cycle interrupt accept strobe |
| vec_addr | output | VEC_W | Vector address of the accepted source, or 0x000 after reset |
| gie | output | 1 | Current global I-bit |
| irq_pend | output | NUM_IRQ | Pending flags |

## Verification
A request shows up in `irq_pend` one cycle after it is driven. Arbitration uses the registered flags, enables and I-bit. As a result, `take_irq`, the new `vec_addr`, the cleared I-bit and the cleared flag all appear one cycle after the flag became visible, or one cycle after `gie` went high. The bench drives inputs on the falling edge and steps exactly one rising edge per operation. It samples each result on the following falling edge. Every enable, I-bit and request combination is swept, so each expected value is tied to a known edge count.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int IVC_NUM_IRQ_DEF = 2;
  localparam int IVC_VEC_W_DEF   = 12;

  function automatic int ivc_idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  typedef enum logic [1:0] {
    GIE_HOLD = 2'd0,
    GIE_CLR  = 2'd1,
    GIE_LOAD = 2'd2,
    GIE_SET  = 2'd3
  } gie_op_e;
endpackage

// File: rtl/ivc_pend_reg.sv
module ivc_pend_reg #(
  parameter int NUM_IRQ = ivc_pkg::IVC_NUM_IRQ_DEF
) (
  input  logic               clk,
  input  logic               clr_all,
  input  logic [NUM_IRQ-1:0] set_req,
  input  logic [NUM_IRQ-1:0] clr_grant,
  output logic [NUM_IRQ-1:0] pend
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk) begin
        if (clr_all) begin
          flag_q <= 1'b0;
        end else if (set_req[gi]) begin
          flag_q <= 1'b1;
        end else if (clr_grant[gi]) begin
          flag_q <= 1'b0;
        end
      end
      assign pend[gi] = flag_q;
    end
  endgenerate
endmodule

// File: rtl/ivc_prio_arb.sv
module ivc_prio_arb #(
  parameter int NUM_IRQ = ivc_pkg::IVC_NUM_IRQ_DEF,
  localparam int IDX_W  = ivc_pkg::ivc_idx_w(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] en,
  input  logic               gie,
  output logic               hit,
  output logic [NUM_IRQ-1:0] grant,
  output logic [IDX_W-1:0]   idx
);
  logic [NUM_IRQ-1:0] ready;
  assign ready = pend & en & {NUM_IRQ{gie}};

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_grant
      if (gi == 0) begin : g_first
        assign grant[gi] = ready[gi];
      end else begin : g_rest
        assign grant[gi] = ready[gi] & ~(|ready[gi-1:0]);
      end
    end
  endgenerate

  assign hit = |ready;

  always_comb begin
    idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (ready[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ivc_gie_ctrl.sv
module ivc_gie_ctrl (
  input  logic clk,
  input  logic clr_all,
  input  logic accept,
  input  logic wr,
  input  logic wdata,
  input  logic reti,
  output logic gie
);
  import ivc_pkg::*;

  gie_op_e op;
  logic    gie_q;

  always_comb begin
    if (accept)    op = GIE_CLR;
    else if (wr)   op = GIE_LOAD;
    else if (reti) op = GIE_SET;
    else           op = GIE_HOLD;
  end

  always_ff @(posedge clk) begin
    if (clr_all) begin
      gie_q <= 1'b0;
    end else begin
      case (op)
        GIE_CLR:  gie_q <= 1'b0;
        GIE_LOAD: gie_q <= wdata;
        GIE_SET:  gie_q <= 1'b1;
        default:  gie_q <= gie_q;
      endcase
    end
  end

  assign gie = gie_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_IRQ = ivc_pkg::IVC_NUM_IRQ_DEF,
  parameter int VEC_W   = ivc_pkg::IVC_VEC_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sys_rst_req,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               en_wr,
  input  logic [NUM_IRQ-1:0] en_wdata,
  input  logic               gie_wr,
  input  logic               gie_wdata,
  input  logic               reti,
  output logic               take_irq,
  output logic [VEC_W-1:0]   vec_addr,
  output logic               gie,
  output logic [NUM_IRQ-1:0] irq_pend
);
  localparam int IDX_W = ivc_pkg::ivc_idx_w(NUM_IRQ);

  logic               rst_any;
  logic [NUM_IRQ-1:0] en_q;
  logic               hit;
  logic [NUM_IRQ-1:0] grant;
  logic [IDX_W-1:0]   win_idx;
  logic               take_q;
  logic [VEC_W-1:0]   vec_q;

  assign rst_any = rst | sys_rst_req;

  always_ff @(posedge clk) begin
    if (rst_any)     en_q <= '0;
    else if (en_wr)  en_q <= en_wdata;
  end

  ivc_pend_reg #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk       (clk),
    .clr_all   (rst_any),
    .set_req   (irq_req),
    .clr_grant (grant),
    .pend      (irq_pend)
  );

  ivc_prio_arb #(.NUM_IRQ(NUM_IRQ)) u_arb (
    .pend  (irq_pend),
    .en    (en_q),
    .gie   (gie),
    .hit   (hit),
    .grant (grant),
    .idx   (win_idx)
  );

  ivc_gie_ctrl u_gie (
    .clk     (clk),
    .clr_all (rst_any),
    .accept  (hit),
    .wr      (gie_wr),
    .wdata   (gie_wdata),
    .reti    (reti),
    .gie     (gie)
  );

  always_ff @(posedge clk) begin
    if (rst_any) begin
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= hit;
      if (hit) vec_q <= VEC_W'(win_idx) + VEC_W'(1);
    end
  end

  assign take_irq = take_q;
  assign vec_addr = vec_q;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NUM_IRQ = 2,
  parameter int VEC_W   = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               sys_rst_req,
  input logic               reti,
  input logic               gie_wr,
  input logic               take_irq,
  input logic [VEC_W-1:0]   vec_addr,
  input logic               gie,
  input logic [NUM_IRQ-1:0] irq_pend,
  input logic [NUM_IRQ-1:0] en
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |=> (vec_addr == '0 && !take_irq && !gie && irq_pend == '0 && en == '0)); // R1

  AST_RESET_BLOCKS_TAKE: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |=> !take_irq); // R2

  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> (vec_addr >= VEC_W'(1) && vec_addr <= VEC_W'(NUM_IRQ))); // R3

  AST_TAKE_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> $past(gie)); // R5

  AST_LOWER_FIRST: assert property (@(posedge clk) disable iff (rst)
    (take_irq && vec_addr > VEC_W'(1)) |-> !$past(irq_pend[0] && en[0])); // R6

  AST_TAKE_CLEARS_GIE: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> !gie); // R7

  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    take_irq |=> !take_irq); // R7

  AST_RETI_SETS_GIE: assert property (@(posedge clk) disable iff (rst)
    (reti && !gie_wr && !gie && !sys_rst_req) |=> gie); // R8

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!take_irq && !sys_rst_req) |=> (take_irq || $stable(vec_addr))); // R10
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sys_rst_req (sys_rst_req),
  .reti        (reti),
  .gie_wr      (gie_wr),
  .take_irq    (take_irq),
  .vec_addr    (vec_addr),
  .gie         (gie),
  .irq_pend    (irq_pend),
  .en          (en_q)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 2;
  localparam int VW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sys_rst_req = 1'b0;
  logic [N-1:0]  irq_req = '0;
  logic          en_wr = 1'b0;
  logic [N-1:0]  en_wdata = '0;
  logic          gie_wr = 1'b0;
  logic          gie_wdata = 1'b0;
  logic          reti = 1'b0;
  logic          take_irq;
  logic [VW-1:0] vec_addr;
  logic          gie;
  logic [N-1:0]  irq_pend;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl #(.NUM_IRQ(N), .VEC_W(VW)) u_irq_vector_ctrl (
    .clk(clk), .rst(rst), .sys_rst_req(sys_rst_req), .irq_req(irq_req),
    .en_wr(en_wr), .en_wdata(en_wdata), .gie_wr(gie_wr), .gie_wdata(gie_wdata),
    .reti(reti), .take_irq(take_irq), .vec_addr(vec_addr), .gie(gie),
    .irq_pend(irq_pend)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_reset_state(input string tag);
    check({tag, " vec"},  int'(vec_addr), 0);
    check({tag, " take"}, int'(take_irq), 0);
    check({tag, " gie"},  int'(gie), 0);
    check({tag, " pend"}, int'(irq_pend), 0);
  endtask

  initial begin
    @(negedge clk);
    step();
    step();
    rst = 1'b0;
    check_reset_state("R1 block reset");

    // R1: enables cleared by reset -> pending with gie set is not taken
    irq_req = 2'b11; step(); irq_req = '0;
    gie_wr = 1'b1; gie_wdata = 1'b1; step(); gie_wr = 1'b0;
    step();
    check("R1 enables cleared, no take", int'(take_irq), 0);
    check("R1 pending kept", int'(irq_pend), 3);

    // Exhaustive sweep over enables, I-bit and request pattern
    for (int e = 0; e < 4; e++) begin
      for (int g = 0; g < 2; g++) begin
        for (int p = 0; p < 4; p++) begin
          int rdy;
          int w;
          int rem;
          sys_rst_req = 1'b1; step(); sys_rst_req = 1'b0;
          check_reset_state("R1 reset request");

          en_wr = 1'b1; en_wdata = N'(e); irq_req = N'(p); step();
          en_wr = 1'b0; irq_req = '0;
          check("R4 pending set", int'(irq_pend), p);
          check("R5 no take before gie", int'(take_irq), 0);

          gie_wr = 1'b1; gie_wdata = g[0]; step(); gie_wr = 1'b0;
          check("R9 gie load", int'(gie), g);
          check("R5 no take on gie write edge", int'(take_irq), 0);

          step();
          rdy = p & e;
          if (g == 1 && rdy != 0) begin
            w = rdy[0] ? 0 : 1;
            check("R5 take", int'(take_irq), 1);
            check("R3 R6 vector", int'(vec_addr), w + 1);
            check("R7 gie cleared", int'(gie), 0);
            check("R7 pending cleared", int'(irq_pend), p & ~(1 << w));
            step();
            check("R7 single pulse", int'(take_irq), 0);
            check("R10 vec held", int'(vec_addr), w + 1);
            check("R4 held while masked", int'(irq_pend), p & ~(1 << w));
            rem = p & ~(1 << w) & e;
            if (rem != 0) begin
              reti = 1'b1; step(); reti = 1'b0;
              check("R8 reti sets gie", int'(gie), 1);
              check("R8 no take yet", int'(take_irq), 0);
              step();
              check("R6 second take", int'(take_irq), 1);
              check("R6 second vector", int'(vec_addr), 2);
              check("R7 all cleared", int'(irq_pend), 0);
            end
          end else begin
            check("R5 masked no take", int'(take_irq), 0);
            check("R4 pending held", int'(irq_pend), p);
            check("R9 gie unchanged", int'(gie), g);
            check("R10 vec held at reset value", int'(vec_addr), 0);
          end
        end
      end
    end

    // R2: reset request in the arbitration cycle wins
    sys_rst_req = 1'b1; step(); sys_rst_req = 1'b0;
    en_wr = 1'b1; en_wdata = 2'b11; irq_req = 2'b01; step();
    en_wr = 1'b0; irq_req = '0;
    gie_wr = 1'b1; gie_wdata = 1'b1; step(); gie_wr = 1'b0;
    sys_rst_req = 1'b1; step(); sys_rst_req = 1'b0;
    check("R2 no take under reset", int'(take_irq), 0);
    check("R2 reset vector", int'(vec_addr), 0);
    check("R2 pend cleared", int'(irq_pend), 0);
    check("R2 gie cleared", int'(gie), 0);

    // R8: reti while a timer request is pending and enabled
    en_wr = 1'b1; en_wdata = 2'b10; irq_req = 2'b10; step();
    en_wr = 1'b0; irq_req = '0;
    reti = 1'b1; step(); reti = 1'b0;
    check("R8 gie set by reti", int'(gie), 1);
    step();
    check("R8 take after reti", int'(take_irq), 1);
    check("R3 timer vector", int'(vec_addr), 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule